// File: doc/BRIEF.md
# Turn-On Load Diagnostic Sequencer

This block runs the power-up speaker check for a single bridge output pair. When a check is requested, it raises a test-pulse enable. While that enable is high, the analog side sources a slow current into the positive output and sinks it from the negative output. The block counts millisecond ticks across the pulse. At the close of the pulse plateau it samples the digital comparator flags. The flags come from two places: the output-voltage window comparators on each leg, and the load-resistance comparators. There are two load comparator sets, and a mode select chosen at request time picks one of them.

The sampled flags update a set of held decisions, one for each leg and one for the load. A fixed priority then folds those decisions into four reported fault bits: ground short, supply short, shorted load and open load. A done flag goes with them. The report stays frozen until a status read has taken place and a fresh request arrives. A controller can therefore read a stable result at any time after completion. A further bit marks the result as coming from the power-up test rather than from continuous monitoring; this block always drives it low.

Top module: `turnon_diag_seq`

## Requirements
- R1: After synchronous reset: pulse_en, busy and done are 0, all four fault bits are 0, and every held decision is cleared (both legs fault-free, load normal).
- R2: A start_req sampled while idle and armed starts a check. pulse_en and busy go high on the following cycle and done goes low. Reset arms the block, and a status_rd sampled while idle re-arms it. Starting a check disarms it.
- R3: pulse_en stays high until the clock edge that samples the PULSE_MS-th tick_ms pulse seen while it is high. On that edge the flags are captured, done goes to 1, and pulse_en and busy go to 0.
- R4: The voltage windows do not depend on mode. On a leg, the low flag (below the ground threshold) means a ground short, the high flag (above the supply threshold) means a supply short, and the ok flag clears both. Priority among the flags is low, then high, then ok.
- R5: line_mode is latched when a check starts. 0 selects the amplifier-mode load flags (amp_*) and 1 selects the line-driver flags (ldrv_*). Within the selected set, priority is short, then open, then ok.
- R6: When a leg raises none of its flags at capture, that leg's previous decision is kept. When the selected load set raises none of its flags, the previous load class is kept.
- R7: If the source (positive) leg is shorted to ground, the report is ground only, with no open or shorted load. If the sink (negative) leg is shorted to ground and the load is open, the report is open only. A ground short together with a supply short reports both bits.
- R8: A supply short on either leg suppresses the shorted-load and open-load bits.
- R9: The fault bits and done change only on a capture edge. A start_req while busy, or while idle without a status_rd since the last completion, has no effect.
- R10: perm_flag is 0 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_ms | input | 1 | One-cycle strobe every millisecond |
| start_req | input | 1 | Request a power-up load check |
| status_rd | input | 1 | Controller has read the result; re-arms when idle |
| line_mode | input | 1 | 0 amplifier load thresholds, 1 line-driver thresholds |
| pos_lo | input | 1 | Positive leg below ground-short threshold |
| pos_hi | input | 1 | Positive leg above supply-short threshold |
| pos_ok | input | 1 | Positive leg inside normal window |
| neg_lo | input | 1 | Negative leg below ground-short threshold |
| neg_hi | input | 1 | Negative leg above supply-short threshold |
| neg_ok | input | 1 | Negative leg inside normal window |
| amp_rshort | input | 1 | Amplifier set: load below shorted limit |
| amp_rok | input | 1 | Amplifier set: load inside normal range |
| amp_ropen | input | 1 | Amplifier set: load above open limit |
| ldrv_rshort | input | 1 | Line-driver set: load below shorted limit |
| ldrv_rok | input | 1 | Line-driver set: load inside normal range |
| ldrv_ropen | input | 1 | Line-driver set: load above open limit |
| pulse_en | output | 1 | Test current enable (source on positive, sink on negative) |
| busy | output | 1 | A check is in progress |
| done | output | 1 | Result of the last check is available |
| flt_gnd | output | 1 | Reported ground short |
| flt_vs | output | 1 | Reported supply short |
| flt_short | output | 1 | Reported shorted load |
| flt_open | output | 1 | Reported open load |
| perm_flag | output | 1 | Result-origin bit, always 0 for this test |

## Verification
Internal state shows up only at capture. A wrong held decision stays invisible until the next check that lands in a comparator gap, and then it appears as a stale fault bit. For that reason the bench runs gap checks directly after fault checks. A bad arming or mode latch shows up within one cycle of start_req, as pulse_en rising or staying low wrongly, or as the wrong load set being decoded at capture. A tick counter that is off by one moves the fall of pulse_en by a whole tick period, which the bench measures by counting ticks inside the pulse.

// File: rtl/diag_pkg.sv
package diag_pkg;

    typedef enum logic [1:0] {
        LD_NORMAL = 2'd0,
        LD_SHORT  = 2'd1,
        LD_OPEN   = 2'd2
    } load_cls_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_PULSE = 1'b1
    } seq_st_e;

    // Voltage-window flags of one output leg
    typedef struct packed {
        logic lo;
        logic hi;
        logic ok;
    } vwin_t;

    // One set of load-resistance flags
    typedef struct packed {
        logic shrt;
        logic ok;
        logic open;
    } rwin_t;

    // Held decision for one leg
    typedef struct packed {
        logic gnd;
        logic vs;
    } leg_dec_t;

    typedef struct packed {
        leg_dec_t  src;
        leg_dec_t  snk;
        load_cls_e load;
    } diag_dec_t;

    typedef struct packed {
        logic gnd;
        logic vs;
        logic shrt;
        logic open;
    } diag_res_t;

    localparam diag_dec_t DEC_CLEAR = '{src: '0, snk: '0, load: LD_NORMAL};

    function automatic leg_dec_t leg_update(input vwin_t w, input leg_dec_t prev);
        leg_dec_t r;
        r = prev;
        if (w.lo) begin
            r.gnd = 1'b1;
            r.vs  = 1'b0;
        end else if (w.hi) begin
            r.gnd = 1'b0;
            r.vs  = 1'b1;
        end else if (w.ok) begin
            r = '0;
        end
        return r;
    endfunction

    function automatic load_cls_e load_update(input rwin_t w, input load_cls_e prev);
        load_cls_e r;
        r = prev;
        if (w.shrt)
            r = LD_SHORT;
        else if (w.open)
            r = LD_OPEN;
        else if (w.ok)
            r = LD_NORMAL;
        return r;
    endfunction

endpackage

// File: rtl/diag_pulse_timer.sv
module diag_pulse_timer #(
    parameter int PULSE_MS = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    input  logic tick,
    output logic last
);
    localparam int CW = $clog2(PULSE_MS + 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(PULSE_MS - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt_q <= '0;
        else if (run && tick && cnt_q != LAST_CNT)
            cnt_q <= cnt_q + 1'b1;
    end

    assign last = run && tick && (cnt_q == LAST_CNT);

endmodule

// File: rtl/diag_classify.sv
module diag_classify
    import diag_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      capture,
    input  logic      use_line,
    input  vwin_t     leg_win [2],
    input  rwin_t     amp_win,
    input  rwin_t     ldrv_win,
    output diag_dec_t dec_next
);
    diag_dec_t dec_q;
    rwin_t     sel_win;
    leg_dec_t  leg_prev [2];
    leg_dec_t  leg_new  [2];

    assign sel_win     = use_line ? ldrv_win : amp_win;
    assign leg_prev[0] = dec_q.src;
    assign leg_prev[1] = dec_q.snk;

    for (genvar g = 0; g < 2; g++) begin : g_leg
        assign leg_new[g] = capture ? leg_update(leg_win[g], leg_prev[g]) : leg_prev[g];
    end

    always_comb begin
        dec_next.src  = leg_new[0];
        dec_next.snk  = leg_new[1];
        dec_next.load = capture ? load_update(sel_win, dec_q.load) : dec_q.load;
    end

    always_ff @(posedge clk) begin
        if (rst)
            dec_q <= DEC_CLEAR;
        else
            dec_q <= dec_next;
    end

endmodule

// File: rtl/diag_encode.sv
module diag_encode
    import diag_pkg::*;
(
    input  diag_dec_t dec,
    output diag_res_t res
);
    logic gnd_any, vs_any, ld_short, ld_open;

    always_comb begin
        gnd_any  = dec.src.gnd | dec.snk.gnd;
        vs_any   = dec.src.vs  | dec.snk.vs;
        ld_short = (dec.load == LD_SHORT);
        ld_open  = (dec.load == LD_OPEN);

        res.vs   = vs_any;
        // sink-side ground short yields to an open load
        res.gnd  = dec.src.gnd | (dec.snk.gnd & ~ld_open);
        res.shrt = ld_short & ~gnd_any & ~vs_any;
        res.open = ld_open & ~vs_any & ~dec.src.gnd;
    end

endmodule

// File: rtl/turnon_diag_seq.sv
module turnon_diag_seq
    import diag_pkg::*;
#(
    parameter int PULSE_MS = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_ms,
    input  logic start_req,
    input  logic status_rd,
    input  logic line_mode,
    input  logic pos_lo,
    input  logic pos_hi,
    input  logic pos_ok,
    input  logic neg_lo,
    input  logic neg_hi,
    input  logic neg_ok,
    input  logic amp_rshort,
    input  logic amp_rok,
    input  logic amp_ropen,
    input  logic ldrv_rshort,
    input  logic ldrv_rok,
    input  logic ldrv_ropen,
    output logic pulse_en,
    output logic busy,
    output logic done,
    output logic flt_gnd,
    output logic flt_vs,
    output logic flt_short,
    output logic flt_open,
    output logic perm_flag
);
    seq_st_e   st_q;
    logic      armed_q;
    logic      mode_q;
    logic      done_q;
    logic      accept;
    logic      last;
    diag_res_t res_q;
    diag_res_t res_d;
    diag_dec_t dec_next;
    vwin_t     leg_win [2];
    rwin_t     amp_win, ldrv_win;

    assign leg_win[0] = '{lo: pos_lo, hi: pos_hi, ok: pos_ok};
    assign leg_win[1] = '{lo: neg_lo, hi: neg_hi, ok: neg_ok};
    assign amp_win    = '{shrt: amp_rshort,  ok: amp_rok,  open: amp_ropen};
    assign ldrv_win   = '{shrt: ldrv_rshort, ok: ldrv_rok, open: ldrv_ropen};

    assign accept = (st_q == ST_IDLE) && armed_q && start_req;

    diag_pulse_timer #(.PULSE_MS(PULSE_MS)) timer_i (
        .clk   (clk),
        .rst   (rst),
        .clear (accept),
        .run   (st_q == ST_PULSE),
        .tick  (tick_ms),
        .last  (last)
    );

    diag_classify classify_i (
        .clk      (clk),
        .rst      (rst),
        .capture  (last),
        .use_line (mode_q),
        .leg_win  (leg_win),
        .amp_win  (amp_win),
        .ldrv_win (ldrv_win),
        .dec_next (dec_next)
    );

    diag_encode encode_i (
        .dec (dec_next),
        .res (res_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            armed_q <= 1'b1;
            mode_q  <= 1'b0;
            done_q  <= 1'b0;
            res_q   <= '0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (accept) begin
                        st_q    <= ST_PULSE;
                        armed_q <= 1'b0;
                        mode_q  <= line_mode;
                        done_q  <= 1'b0;
                    end else if (status_rd) begin
                        armed_q <= 1'b1;
                    end
                end
                ST_PULSE: begin
                    if (last) begin
                        st_q   <= ST_IDLE;
                        done_q <= 1'b1;
                        res_q  <= res_d;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign pulse_en  = (st_q == ST_PULSE);
    assign busy      = (st_q == ST_PULSE);
    assign done      = done_q;
    assign flt_gnd   = res_q.gnd;
    assign flt_vs    = res_q.vs;
    assign flt_short = res_q.shrt;
    assign flt_open  = res_q.open;
    assign perm_flag = 1'b0;

endmodule

// File: rtl/diag_seq_chk.sv
module diag_seq_chk (
    input logic clk,
    input logic rst,
    input logic tick_ms,
    input logic start_req,
    input logic pulse_en,
    input logic done,
    input logic flt_gnd,
    input logic flt_vs,
    input logic flt_short,
    input logic flt_open
);
    AST_START_FROM_REQ: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse_en) |-> $past(start_req)) else $error("start without request"); // R2

    AST_DONE_AFTER_TICK: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> ($past(pulse_en) && $past(tick_ms) && !pulse_en)) else $error("done timing"); // R3

    AST_PULSE_NOT_DONE: assert property (@(posedge clk) disable iff (rst)
        pulse_en |-> !done) else $error("pulse with done"); // R3

    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        !$rose(done) |-> $stable({flt_gnd, flt_vs, flt_short, flt_open})) else $error("result moved"); // R9

    AST_GND_NO_SHORT: assert property (@(posedge clk) disable iff (rst)
        flt_gnd |-> !flt_short) else $error("gnd with short load"); // R7

    AST_VS_OVER_LOAD: assert property (@(posedge clk) disable iff (rst)
        flt_vs |-> (!flt_short && !flt_open)) else $error("vs with load fault"); // R8

endmodule

bind turnon_diag_seq diag_seq_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .tick_ms   (tick_ms),
    .start_req (start_req),
    .pulse_en  (pulse_en),
    .done      (done),
    .flt_gnd   (flt_gnd),
    .flt_vs    (flt_vs),
    .flt_short (flt_short),
    .flt_open  (flt_open)
);

// File: tb/turnon_diag_seq_tb_top.sv
`timescale 1ns/1ps
module turnon_diag_seq_tb_top;
    localparam int PMS      = 4;
    localparam int TICK_DIV = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_ms = 1'b0;
    logic start_req = 1'b0, status_rd = 1'b0, line_mode = 1'b0;
    logic pos_lo = 0, pos_hi = 0, pos_ok = 0, neg_lo = 0, neg_hi = 0, neg_ok = 0;
    logic amp_rshort = 0, amp_rok = 0, amp_ropen = 0;
    logic ldrv_rshort = 0, ldrv_rok = 0, ldrv_ropen = 0;
    logic pulse_en, busy, done, flt_gnd, flt_vs, flt_short, flt_open, perm_flag;

    int checks = 0, fails = 0, ticks_seen = 0, tdiv = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    turnon_diag_seq #(.PULSE_MS(PMS)) dut_i (
        .clk(clk), .rst(rst), .tick_ms(tick_ms), .start_req(start_req),
        .status_rd(status_rd), .line_mode(line_mode),
        .pos_lo(pos_lo), .pos_hi(pos_hi), .pos_ok(pos_ok),
        .neg_lo(neg_lo), .neg_hi(neg_hi), .neg_ok(neg_ok),
        .amp_rshort(amp_rshort), .amp_rok(amp_rok), .amp_ropen(amp_ropen),
        .ldrv_rshort(ldrv_rshort), .ldrv_rok(ldrv_rok), .ldrv_ropen(ldrv_ropen),
        .pulse_en(pulse_en), .busy(busy), .done(done), .flt_gnd(flt_gnd),
        .flt_vs(flt_vs), .flt_short(flt_short), .flt_open(flt_open), .perm_flag(perm_flag)
    );

    always @(negedge clk) begin
        tdiv    <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
        tick_ms <= (tdiv == TICK_DIV - 1);
    end

    always @(posedge clk) if (pulse_en && tick_ms) ticks_seen <= ticks_seen + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic set_flags(input logic [2:0] pv, input logic [2:0] nv,
                             input logic [2:0] av, input logic [2:0] lv);
        {pos_lo, pos_hi, pos_ok}            = pv;
        {neg_lo, neg_hi, neg_ok}            = nv;
        {amp_rshort, amp_rok, amp_ropen}    = av;
        {ldrv_rshort, ldrv_rok, ldrv_ropen} = lv;
    endtask

    task automatic read_pulse();
        @(negedge clk) status_rd = 1'b1;
        @(negedge clk) status_rd = 1'b0;
    endtask

    // runs one check; flips line_mode right after the start to prove it is latched
    task automatic run_check(input string req, input logic mode, input logic flip,
                             input logic [3:0] exp_res);
        int base, wait_n;
        read_pulse();
        @(negedge clk);
        line_mode = mode;
        start_req = 1'b1;
        base = ticks_seen;
        @(negedge clk);
        start_req = 1'b0;
        if (flip) line_mode = ~mode;
        chk({req, " R2 pulse_en after start"}, pulse_en, 1'b1);
        chk({req, " R2 done cleared"}, done, 1'b0);
        wait_n = 0;
        while (!done && wait_n < 400) begin
            @(negedge clk);
            wait_n++;
        end
        chk({req, " R3 done set"}, done, 1'b1);
        chk({req, " R3 pulse ended"}, pulse_en, 1'b0);
        chk({req, " R3 ticks in pulse"}, ticks_seen - base, PMS);
        chk({req, " result"}, {flt_gnd, flt_vs, flt_short, flt_open}, exp_res);
        chk({req, " R10 perm_flag"}, perm_flag, 1'b0);
        line_mode = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 pulse_en", pulse_en, 1'b0);
        chk("R1 busy", busy, 1'b0);
        chk("R1 done", done, 1'b0);
        chk("R1 faults", {flt_gnd, flt_vs, flt_short, flt_open}, 4'b0000);
        chk("R10 perm_flag reset", perm_flag, 1'b0);
    endtask

    task automatic t_normal();
        set_flags(3'b001, 3'b001, 3'b010, 3'b000);
        run_check("R4 normal amp", 1'b0, 1'b0, 4'b0000);
    endtask

    task automatic t_double_faults();
        set_flags(3'b100, 3'b001, 3'b001, 3'b000);
        run_check("R7 src gnd + open", 1'b0, 1'b0, 4'b1000);
        set_flags(3'b001, 3'b100, 3'b001, 3'b000);
        run_check("R7 snk gnd + open", 1'b0, 1'b0, 4'b0001);
        set_flags(3'b100, 3'b010, 3'b010, 3'b000);
        run_check("R7 gnd + vs", 1'b0, 1'b0, 4'b1100);
    endtask

    task automatic t_vs_priority();
        // line mode, supply short on positive leg, line set says shorted load
        set_flags(3'b010, 3'b001, 3'b010, 3'b100);
        run_check("R8 R4 vs over short", 1'b1, 1'b0, 4'b0100);
        set_flags(3'b001, 3'b010, 3'b001, 3'b000);
        run_check("R8 vs over open", 1'b0, 1'b0, 4'b0100);
    endtask

    task automatic t_mode_select();
        set_flags(3'b001, 3'b001, 3'b010, 3'b100);
        run_check("R5 line set latched", 1'b1, 1'b1, 4'b0010);
        set_flags(3'b001, 3'b001, 3'b010, 3'b100);
        run_check("R5 amp set latched", 1'b0, 1'b1, 4'b0000);
        set_flags(3'b001, 3'b001, 3'b100, 3'b010);
        run_check("R5 amp short", 1'b0, 1'b0, 4'b0010);
    endtask

    task automatic t_gap_hold();
        set_flags(3'b000, 3'b000, 3'b000, 3'b000);
        run_check("R6 gap keeps short load", 1'b0, 1'b0, 4'b0010);
        set_flags(3'b100, 3'b001, 3'b000, 3'b000);
        run_check("R6 gap load, src gnd", 1'b0, 1'b0, 4'b1000);
    endtask

    task automatic t_ignored_start();
        // no status read since completion: start must not run
        set_flags(3'b001, 3'b001, 3'b010, 3'b000);
        @(negedge clk) start_req = 1'b1;
        @(negedge clk) start_req = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 unarmed start ignored", pulse_en, 1'b0);
        chk("R9 result held", {done, flt_gnd, flt_vs, flt_short, flt_open}, 5'b11000);
    endtask

    task automatic t_busy_start();
        int base, wait_n;
        set_flags(3'b001, 3'b001, 3'b010, 3'b000);
        read_pulse();
        base = ticks_seen;
        @(negedge clk) start_req = 1'b1;
        @(negedge clk) start_req = 1'b0;
        repeat (TICK_DIV + 2) @(negedge clk);
        status_rd = 1'b1;
        start_req = 1'b1;
        @(negedge clk);
        status_rd = 1'b0;
        start_req = 1'b0;
        wait_n = 0;
        while (!done && wait_n < 400) begin
            @(negedge clk);
            wait_n++;
        end
        chk("R9 busy start no restart", ticks_seen - base, PMS);
        @(negedge clk) start_req = 1'b1;
        @(negedge clk) start_req = 1'b0;
        chk("R9 read during pulse does not arm", pulse_en, 1'b0);
        chk("R9 busy result", {flt_gnd, flt_vs, flt_short, flt_open}, 4'b0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_normal();
        t_double_faults();
        t_vs_priority();
        t_mode_select();
        t_gap_hold();
        t_ignored_start();
        t_busy_start();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule